// File: doc/BRIEF.md
# Programmable Multiframe Sync Pulse Generator

This block keeps track of the frame position inside a signaling multiframe on the system side of a T1/E1 framer. A frame-start strobe steps a frame counter. In T1 operation the counter runs over a 24-frame multiframe numbered 1 to 24. In E1 operation it runs over a 16-frame multiframe numbered 0 to 15.

A 5-bit offset selects the frame whose start strobe carries a one-cycle multiframe sync pulse. A flag marks the frames that carry signaling. The offset and the mode are sampled only at a multiframe boundary, so a change made in the middle of a multiframe never produces a stray pulse.

In transparent mode, a receive-side alignment event forces the counter to restart the multiframe. It restarts at the first frame plus a fixed lag, and no alarm is raised. Whenever transparent mode is active, the sync pin's direction control is forced to output.

Top module: `mf_sync_gen`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `frame_num` is the last frame of the mode present at reset: 24 in T1 (`e1_mode`=0) or 15 in E1 (`e1_mode`=1). `sync_pulse` is 0 and `sig_frame` matches that frame. The offset and mode present at reset become the active configuration.
- R2: In T1, each `frame_strobe` advances `frame_num` by one, one cycle later. After 24 it goes to 1. Without a strobe, `frame_num` holds.
- R3: In E1, each strobe advances `frame_num` by one. After 15 it goes to 0.
- R4: In T1 with offset value v in 0..23, `sync_pulse` is high for exactly the one cycle of the strobe that moves the counter into frame v+1.
- R5: In T1, offset values 24 to 31 produce no pulse.
- R6: In E1, offset bit 4 is ignored and `sync_pulse` accompanies the strobe entering frame `offset[3:0]`.
- R7: In T1, `sig_frame` is 1 exactly when `frame_num` is 6, 12, 18 or 24.
- R8: In E1, `sig_frame` is 1 in every frame except frame 0.
- R9: The values of `offset` and `e1_mode` are sampled only by a strobe that leaves the last frame of the multiframe, or by a realignment (R10). A change at any other time has no effect until then.
- R10: When `thru_en`=1, a strobe with `rx_align`=1 reloads the configuration. It also moves the counter to the new mode's first frame (1 in T1, 0 in E1) plus ALIGN_LAG (0..15), and the pulse rule applies to that frame.
- R11: When `thru_en`=0, `rx_align` has no effect on counting or pulses.
- R12: `sync_oe` is 1 whenever `thru_en` or `sync_oe_cfg` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_strobe | input | 1 | One-cycle frame start |
| e1_mode | input | 1 | 0 = T1, 1 = E1 |
| offset | input | 5 | Sync frame selection |
| thru_en | input | 1 | Transparent realignment enable |
| rx_align | input | 1 | Receive multiframe alignment event, sampled with the strobe |
| sync_oe_cfg | input | 1 | Configured sync pin direction, 1 = output |
| sync_pulse | output | 1 | Multiframe sync pulse |
| frame_num | output | 5 | Current frame number |
| sig_frame | output | 1 | Current frame carries signaling |
| sync_oe | output | 1 | Effective sync pin output enable |

## Verification
The hardest situations to reach are configuration changes in the middle of a multiframe and realignments. For a mid-multiframe change, the pulse must stay on the old frame until the wrap. For a realignment, the counter must jump and pick up the new offset at once. The stimulus changes the offset and the mode several frames before a boundary. It also raises the alignment event part-way through a multiframe, both with transparent mode on and with it off. A bench model predicts every frame number, flag and pulse across these jumps.

// File: rtl/mf_sync_gen.sv
`timescale 1ns/1ps
module mf_sync_gen #(
  parameter int ALIGN_LAG = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_strobe,
  input  logic       e1_mode,
  input  logic [4:0] offset,
  input  logic       thru_en,
  input  logic       rx_align,
  input  logic       sync_oe_cfg,
  output logic       sync_pulse,
  output logic [4:0] frame_num,
  output logic       sig_frame,
  output logic       sync_oe
);
  localparam logic [4:0] T1_FIRST = 5'd1;
  localparam logic [4:0] T1_LAST  = 5'd24;
  localparam logic [4:0] E1_FIRST = 5'd0;
  localparam logic [4:0] E1_LAST  = 5'd15;
  localparam logic [4:0] LAG      = 5'(ALIGN_LAG);

  logic       act_e1;
  logic [4:0] act_off;
  logic [4:0] cnt;

  logic       at_last, realign, reload, nxt_e1, hit;
  logic [4:0] nxt_off, nxt_cnt, first_frm;

  assign at_last   = cnt == (act_e1 ? E1_LAST : T1_LAST);
  assign realign   = frame_strobe & thru_en & rx_align;
  assign reload    = (frame_strobe & at_last) | realign;
  assign nxt_e1    = reload ? e1_mode : act_e1;
  assign nxt_off   = reload ? offset : act_off;
  assign first_frm = nxt_e1 ? E1_FIRST : T1_FIRST;

  always_comb begin
    if (realign)      nxt_cnt = first_frm + LAG;
    else if (at_last) nxt_cnt = first_frm;
    else              nxt_cnt = cnt + 5'd1;
  end

  assign hit = nxt_e1 ? (nxt_cnt[3:0] == nxt_off[3:0])
                      : ((nxt_off < 5'd24) && (nxt_cnt == nxt_off + 5'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_e1  <= e1_mode;
      act_off <= offset;
      cnt     <= e1_mode ? E1_LAST : T1_LAST;
    end else if (frame_strobe) begin
      act_e1  <= nxt_e1;
      act_off <= nxt_off;
      cnt     <= nxt_cnt;
    end
  end

  assign sync_pulse = frame_strobe & hit;
  assign frame_num  = cnt;
  assign sig_frame  = act_e1 ? (cnt != 5'd0)
                             : (cnt == 5'd6 || cnt == 5'd12 || cnt == 5'd18 || cnt == 5'd24);
  assign sync_oe    = sync_oe_cfg | thru_en;

  // R4
  pulse_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> frame_strobe);

  // R2
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_strobe |=> $stable(frame_num));

  // R3
  e1_range_chk: assert property (@(posedge clk) disable iff (rst)
    act_e1 |-> frame_num <= 5'd15);

  // R2
  t1_range_chk: assert property (@(posedge clk) disable iff (rst)
    !act_e1 |-> (frame_num >= 5'd1 && frame_num <= 5'd24));

  // R5
  t1_no_oob_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> (act_e1 || act_off < 5'd24));

  // R4
  pulse_lands_on_target_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> (act_e1 ? frame_num[3:0] == act_off[3:0] : frame_num == act_off + 5'd1));

  // R12
  thru_forces_oe_chk: assert property (@(posedge clk) disable iff (rst)
    thru_en |-> sync_oe);
endmodule

// File: tb/mf_sync_gen_tb.sv
`timescale 1ns/1ps
module mf_sync_gen_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1, frame_strobe = 1'b0, e1_mode = 1'b0;
  logic [4:0] offset = 5'd5;
  logic       thru_en = 1'b0, rx_align = 1'b0, sync_oe_cfg = 1'b0;
  logic       sync_pulse, sig_frame, sync_oe;
  logic [4:0] frame_num;

  mf_sync_gen u_dut (
    .clk(clk), .rst(rst), .frame_strobe(frame_strobe), .e1_mode(e1_mode),
    .offset(offset), .thru_en(thru_en), .rx_align(rx_align), .sync_oe_cfg(sync_oe_cfg),
    .sync_pulse(sync_pulse), .frame_num(frame_num), .sig_frame(sig_frame), .sync_oe(sync_oe)
  );

  typedef struct {
    logic [4:0] frame;
    logic       pulse;
    logic       sig;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  logic       m_e1;
  logic [4:0] m_off;
  int         m_cnt;

  function automatic bit m_sig(input logic e1, input int c);
    return e1 ? (c != 0) : (c % 6 == 0);
  endfunction

  task automatic report(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic e1, input logic [4:0] off);
    @(negedge clk);
    rst = 1'b1; e1_mode = e1; offset = off;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_e1 = e1; m_off = off; m_cnt = e1 ? 15 : 24;
    #1;
    report(frame_num == 5'(m_cnt), "R1", "reset frame", frame_num, m_cnt);
    report(sync_pulse == 1'b0, "R1", "reset pulse", sync_pulse, 0);
    report(sig_frame == m_sig(m_e1, m_cnt), "R1", "reset sig", sig_frame, m_sig(m_e1, m_cnt));
  endtask

  task automatic strobe(input int gap, input bit al, input string tag);
    exp_t e;
    bit last, re;
    @(negedge clk);
    repeat (gap) @(negedge clk);
    frame_strobe = 1'b1; rx_align = al;
    last = (m_cnt == (m_e1 ? 15 : 24));
    re   = thru_en && al;
    if (last || re) begin m_e1 = e1_mode; m_off = offset; end
    if (re)        m_cnt = m_e1 ? 0 : 1;
    else if (last) m_cnt = m_e1 ? 0 : 1;
    else           m_cnt = m_cnt + 1;
    e.frame = 5'(m_cnt);
    e.pulse = m_e1 ? (m_cnt == int'(m_off[3:0])) : (m_off < 5'd24 && m_cnt == int'(m_off) + 1);
    e.sig   = m_sig(m_e1, m_cnt);
    e.tag   = tag;
    q.push_back(e);
    @(negedge clk);
    frame_strobe = 1'b0; rx_align = 1'b0;
  endtask

  initial begin : monitor
    bit pend = 1'b0;
    logic obs_pulse = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (pend && q.size() > 0) begin
        e = q.pop_front();
        report(frame_num == e.frame, e.tag, "frame", frame_num, e.frame);
        report(sig_frame == e.sig, e.tag, "sig", sig_frame, e.sig);
        report(obs_pulse == e.pulse, e.tag, "pulse", obs_pulse, e.pulse);
        pend = 1'b0;
      end
      if (frame_strobe) begin
        obs_pulse = sync_pulse;
        pend = 1'b1;
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    do_reset(1'b0, 5'd5);
    // R2 R4 R7 T1 counting and pulse at frame 6
    for (int i = 0; i < 48; i++) strobe(i % 3, 1'b0, "R2_R4_R7");
    // R9 offset changed mid multiframe
    for (int i = 0; i < 10; i++) strobe(0, 1'b0, "R9");
    offset = 5'd23;
    for (int i = 0; i < 40; i++) strobe(0, 1'b0, "R9_R4");
    // R5 out-of-range T1 offset
    offset = 5'd27;
    for (int i = 0; i < 50; i++) strobe(0, 1'b0, "R5");
    // R9 mode change mid multiframe, R6 top bit ignored
    offset = 5'b10011;
    for (int i = 0; i < 5; i++) strobe(0, 1'b0, "R9");
    e1_mode = 1'b1;
    for (int i = 0; i < 50; i++) strobe(1, 1'b0, "R3_R6_R8");
    // R11 alignment event ignored with transparent mode off
    for (int i = 0; i < 4; i++) strobe(0, 1'b0, "R11");
    strobe(0, 1'b1, "R11");
    for (int i = 0; i < 20; i++) strobe(0, 1'b0, "R11");
    // R12 output enable
    @(negedge clk); #1;
    report(sync_oe == 1'b0, "R12", "oe idle", sync_oe, 0);
    sync_oe_cfg = 1'b1; #1;
    report(sync_oe == 1'b1, "R12", "oe cfg", sync_oe, 1);
    sync_oe_cfg = 1'b0; thru_en = 1'b1; #1;
    report(sync_oe == 1'b1, "R12", "oe thru", sync_oe, 1);
    // R10 realign in E1 with new offset taking effect immediately
    offset = 5'd0;
    for (int i = 0; i < 5; i++) strobe(0, 1'b0, "R10");
    strobe(0, 1'b1, "R10");
    for (int i = 0; i < 20; i++) strobe(0, 1'b0, "R10");
    // R10 realign switching to T1
    e1_mode = 1'b0; offset = 5'd0;
    for (int i = 0; i < 3; i++) strobe(0, 1'b0, "R10");
    strobe(0, 1'b1, "R10");
    for (int i = 0; i < 30; i++) strobe(0, 1'b0, "R10_R7");
    // R1 reset into E1
    do_reset(1'b1, 5'd0);
    for (int i = 0; i < 18; i++) strobe(0, 1'b0, "R3_R8");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule